// File: doc/BRIEF.md
# Square Tone Channel with Frequency Sweep

This block produces a one-bit square tone whose pitch is set by an 11-bit frequency word, with a selectable duty pattern and an automatic pitch sweep. Software loads it through a byte-wide register write port: a sweep control field, a duty code, the low byte of the frequency and a final byte that carries the three high frequency bits and a trigger bit. Two enable inputs from a shared prescaler pace the block. `freq_tick_i` pulses once every 32 system clocks. `sweep_tick_i` pulses at the sweep base rate of 128 Hz.

When the channel is triggered, the period counter reloads. The frequency is copied into a hidden shadow register, and the sweep unit works from that copy only. Each sweep update adds the right-shifted shadow to itself or subtracts it, and writes the result back to both the shadow and the frequency register. An upward result that would not fit in 11 bits shuts the channel off. The check runs one step ahead, so a tone whose first sweep step would overflow never starts. The duty sequencer keeps its position across triggers. Volume, length timing and mixing are handled elsewhere.

Top module: `sq_sweep_tone`

## Requirements
- R1: The write port decodes `wr_sel_i` as follows. Code 0 writes the sweep control: bits [6:4] set the update period, bit 3 sets the direction (1 means decrease), bits [2:0] set the shift. Code 1 writes the duty code from bits [7:6]. Code 2 writes frequency bits [7:0]. Code 3 writes frequency bits [10:8] from data bits [2:0], and data bit 7 set to 1 triggers the channel using the new frequency.
- R2: On trigger, and on every terminal count, the period counter reloads with 2048 minus the frequency. One sequencer step therefore lasts 2048 minus f pulses of `freq_tick_i`.
- R3: Each terminal count advances a 3-bit sequencer position by one, wrapping from 7 to 0. The position is 0 after reset.
- R4: The tone level at position p depends on the duty code. Code 00 is high at p=4 only. Code 01 is high at p=4..5. Code 10 is high at p=2..5. Code 11 is low at p=4..5 and high at the other positions.
- R5: A trigger leaves the sequencer position unchanged.
- R6: A trigger copies the frequency into the shadow register. Each sweep update is computed from the shadow, not from the frequency register, even after software rewrites the frequency. The result is written into the frequency register and takes priority over a write to the frequency in the same cycle.
- R7: A sweep update sets the new value to shadow + (shadow >> shift) when the direction bit is 0, and to shadow − (shadow >> shift) when it is 1.
- R8: A trigger loads the sweep tick counter from the period field. With period N > 0, an update happens on every N-th `sweep_tick_i` pulse. With period 0, no update happens.
- R9: With shift 0, sweep ticks never change the frequency and never stop the channel.
- R10: On an upward trigger with a non-zero shift, `active_o` stays 0 if the first computed step exceeds 0x7FF. On an upward update, the channel is cleared if the result exceeds 0x7FF. It is also cleared if the following step computed from that result exceeds 0x7FF.
- R11: A trigger that does not overflow sets `active_o`. While `active_o` is 0, `tone_o` is 0. Register writes still take effect while the channel is inactive.
- R12: Reset sets the duty code to 10, the frequency, shadow and sweep control to 0, the sequencer position to 0 and `active_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 sweep, 1 duty, 2 frequency low, 3 frequency high and trigger) |
| wr_data_i | input | 8 | Write data byte |
| freq_tick_i | input | 1 | Period counter enable, one pulse per 32 system clocks |
| sweep_tick_i | input | 1 | Sweep base-rate enable |
| tone_o | output | 1 | Square tone bit, gated by the active flag |
| active_o | output | 1 | Channel active flag |

## Verification
The bench builds the block with its default parameters: an 11-bit frequency, a 3-bit sequencer and 3-bit sweep period and shift fields. It holds `freq_tick_i` high while it measures. Each sequencer step then lasts exactly 2048 − f cycles. Frequencies near 0x7FF give steps of a few cycles, so every duty code can be checked by counting the high and low times of the tone. A sweep toward 0x7FF with shift 5 reaches the one-step-ahead overflow after two updates. This makes both the overflow at trigger and the overflow during a sweep short enough to observe.

// File: rtl/sq_tone_pkg.sv
package sq_tone_pkg;
  localparam int unsigned PER_W   = 3;
  localparam int unsigned SHIFT_W = 3;

  typedef enum logic [1:0] {
    SEL_SWEEP   = 2'd0,
    SEL_DUTY    = 2'd1,
    SEL_FREQ_LO = 2'd2,
    SEL_FREQ_HI = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PER_W-1:0]   period;
    logic               dec;
    logic [SHIFT_W-1:0] shift;
  } sweep_cfg_t;
endpackage

// File: rtl/sq_period_ctr.sv
module sq_period_ctr #(
  parameter int unsigned FREQ_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              tick_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              step_o
);
  localparam int unsigned CW = FREQ_W + 1;
  localparam logic [CW-1:0] PERIOD_MAX = CW'(1) << FREQ_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;
  logic          at_tc;

  assign reload = PERIOD_MAX - {1'b0, freq_i};
  assign at_tc  = (cnt_q <= CW'(1));
  assign step_o = tick_i & ~trig_i & at_tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (trig_i)      cnt_q <= reload;
    else if (tick_i) begin
      if (at_tc)          cnt_q <= reload;
      else                cnt_q <= cnt_q - CW'(1);
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PERIOD_MAX);

  p_cnt_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !trig_i && !at_tc) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/sq_duty_seq.sv
module sq_duty_seq #(
  parameter int unsigned SEQ_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [1:0] duty_i,
  output logic       tone_raw_o
);
  localparam int unsigned STEPS = 1 << SEQ_W;
  localparam int unsigned E     = STEPS / 8;

  logic [SEQ_W-1:0] pos_q;
  logic [STEPS-1:0] pat [4];

  for (genvar k = 0; k < STEPS; k++) begin : g_pat
    assign pat[0][k] = (k >= 4*E) && (k < 5*E);
    assign pat[1][k] = (k >= 4*E) && (k < 6*E);
    assign pat[2][k] = (k >= 2*E) && (k < 6*E);
    assign pat[3][k] = !((k >= 4*E) && (k < 6*E));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= pos_q + SEQ_W'(1);
  end

  assign tone_raw_o = pat[duty_i][pos_q];

  p_pos_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pos_q == SEQ_W'($past(pos_q) + SEQ_W'(1)));

  // position only moves on a terminal count, so a trigger cannot disturb it
  p_pos_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/sq_sweep.sv
module sq_sweep
  import sq_tone_pkg::*;
#(
  parameter int unsigned FREQ_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [FREQ_W-1:0] trig_freq_i,
  input  logic              tick_i,
  input  logic              active_i,
  input  sweep_cfg_t        cfg_i,
  output logic              trig_ok_o,
  output logic              upd_o,
  output logic [FREQ_W-1:0] upd_freq_o,
  output logic              kill_o
);
  logic [FREQ_W-1:0] shadow_q;
  logic [PER_W-1:0]  per_cnt_q;
  logic [FREQ_W:0]   trig_next, step_next, ahead_next;
  logic              per_tc, fire, shift_on;

  function automatic logic [FREQ_W:0] step_calc(input logic [FREQ_W-1:0] base,
                                                input logic dec,
                                                input logic [SHIFT_W-1:0] sh);
    logic [FREQ_W:0] b, d;
    b = {1'b0, base};
    d = b >> sh;
    step_calc = dec ? (b - d) : (b + d);
  endfunction

  assign shift_on   = (cfg_i.shift != '0);
  assign trig_next  = step_calc(trig_freq_i, cfg_i.dec, cfg_i.shift);
  assign step_next  = step_calc(shadow_q, cfg_i.dec, cfg_i.shift);
  assign ahead_next = step_calc(step_next[FREQ_W-1:0], cfg_i.dec, cfg_i.shift);

  assign trig_ok_o  = !(shift_on && !cfg_i.dec && trig_next[FREQ_W]);

  assign per_tc = (per_cnt_q <= PER_W'(1));
  assign fire   = tick_i & ~trig_i & active_i & per_tc &
                  (cfg_i.period != '0) & shift_on;

  assign upd_o      = fire & ~step_next[FREQ_W];
  assign upd_freq_o = step_next[FREQ_W-1:0];
  // one step ahead: also stop if the step after this one overflows
  assign kill_o     = fire & ~cfg_i.dec & (step_next[FREQ_W] | ahead_next[FREQ_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (trig_i) shadow_q <= trig_freq_i;
    else if (upd_o)  shadow_q <= upd_freq_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      per_cnt_q <= '0;
    else if (trig_i)  per_cnt_q <= cfg_i.period;
    else if (tick_i) begin
      if (per_tc)     per_cnt_q <= cfg_i.period;
      else            per_cnt_q <= per_cnt_q - PER_W'(1);
    end
  end

  p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !upd_o) |=> $stable(shadow_q));

  p_upd_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !cfg_i.dec) |-> upd_freq_o >= shadow_q);

  p_upd_dn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && cfg_i.dec) |-> upd_freq_o <= shadow_q);
endmodule

// File: rtl/sq_sweep_tone.sv
module sq_sweep_tone
  import sq_tone_pkg::*;
#(
  parameter int unsigned FREQ_W = 11,
  parameter int unsigned SEQ_W  = 3,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          freq_tick_i,
  input  logic          sweep_tick_i,
  output logic          tone_o,
  output logic          active_o
);
  localparam int unsigned HI_W  = FREQ_W - DW;
  localparam int unsigned CFG_W = $bits(sweep_cfg_t);

  reg_sel_e          sel;
  sweep_cfg_t        cfg_q;
  logic [1:0]        duty_q;
  logic [FREQ_W-1:0] freq_q, trig_freq, eff_freq, upd_freq;
  logic              active_q, trig, trig_ok, upd, kill, step, tone_raw;

  assign sel       = reg_sel_e'(wr_sel_i);
  assign trig      = wr_en_i && (sel == SEL_FREQ_HI) && wr_data_i[DW-1];
  assign trig_freq = {wr_data_i[HI_W-1:0], freq_q[DW-1:0]};
  assign eff_freq  = trig ? trig_freq : freq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      duty_q <= 2'b10;
    end else if (wr_en_i) begin
      if (sel == SEL_SWEEP) cfg_q  <= sweep_cfg_t'(wr_data_i[CFG_W-1:0]);
      if (sel == SEL_DUTY)  duty_q <= wr_data_i[DW-1:DW-2];
    end
  end

  // sweep write-back wins over a bus write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       freq_q <= '0;
    else if (upd)      freq_q <= upd_freq;
    else if (wr_en_i) begin
      if (sel == SEL_FREQ_LO) freq_q[DW-1:0]     <= wr_data_i;
      if (sel == SEL_FREQ_HI) freq_q[FREQ_W-1:DW] <= wr_data_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    active_q <= 1'b0;
    else if (trig)  active_q <= trig_ok;
    else if (kill)  active_q <= 1'b0;
  end

  sq_period_ctr #(.FREQ_W(FREQ_W)) i_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .tick_i (freq_tick_i),
    .freq_i (eff_freq),
    .step_o (step)
  );

  sq_duty_seq #(.SEQ_W(SEQ_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .duty_i     (duty_q),
    .tone_raw_o (tone_raw)
  );

  sq_sweep #(.FREQ_W(FREQ_W)) i_sweep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .trig_freq_i (trig_freq),
    .tick_i      (sweep_tick_i),
    .active_i    (active_q),
    .cfg_i       (cfg_q),
    .trig_ok_o   (trig_ok),
    .upd_o       (upd),
    .upd_freq_o  (upd_freq),
    .kill_o      (kill)
  );

  assign tone_o   = active_q & tone_raw;
  assign active_o = active_q;

  p_active_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(trig));

  p_kill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill && !trig) |=> !active_q);

  p_sweep_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && wr_en_i && sel == SEL_FREQ_LO) |=> freq_q == $past(upd_freq));
endmodule

// File: tb/test_sq_sweep_tone.sv
module test_sq_sweep_tone;
  localparam int LIM = 20000;

  typedef struct packed {
    logic [1:0]  duty;
    logic [10:0] freq;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 11'h7FF, 16'd1,  16'd7},
    '{2'b01, 11'h7FE, 16'd4,  16'd12},
    '{2'b10, 11'h7FD, 16'd12, 16'd12},
    '{2'b11, 11'h7FC, 16'd24, 16'd8},
    '{2'b10, 11'h7F0, 16'd64, 16'd64},
    '{2'b01, 11'h7E0, 16'd64, 16'd192}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       freq_tick = 1'b0;
  logic       sweep_tick = 1'b0;
  logic       tone, active;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  sq_sweep_tone i_sq_sweep_tone (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .freq_tick_i  (freq_tick),
    .sweep_tick_i (sweep_tick),
    .tone_o       (tone),
    .active_o     (active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig_freq(input logic [10:0] f);
    wr(2'd2, f[7:0]);
    wr(2'd3, {5'b10000, f[10:8]});
  endtask

  task automatic ftick();
    freq_tick = 1'b1;
    @(negedge clk);
    freq_tick = 1'b0;
  endtask

  task automatic stick();
    sweep_tick = 1'b1;
    @(negedge clk);
    sweep_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (tone !== 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
    while (tone !== 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
    while (tone === 1'b1 && guard < LIM) begin hi++; @(negedge clk); guard++; end
    while (tone === 1'b0 && guard < LIM) begin lo++; @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, cnt;
    repeat (3) @(negedge clk);
    chk("R12 active after reset", int'(active), 0);
    chk("R11 tone after reset", int'(tone), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 default duty 10 and position 0; R5 trigger keeps position
    trig_freq(11'h7FF);
    chk("R11 active on trigger", int'(active), 1);
    chk("R12 pos0 duty10 low", int'(tone), 0);
    ftick();
    chk("R3 pos1 low", int'(tone), 0);
    ftick();
    chk("R12 pos2 duty10 high", int'(tone), 1);
    ftick(); ftick();
    wr(2'd1, 8'h00);
    chk("R4 duty00 pos4 high", int'(tone), 1);
    wr(2'd3, 8'h87);
    chk("R5 trigger keeps pos", int'(tone), 1);
    ftick();
    chk("R3 pos5 duty00 low", int'(tone), 0);

    // R1 R2 R4 vector walk
    freq_tick = 1'b1;
    wr(2'd0, 8'h00);
    foreach (VECS[i]) begin
      wr(2'd1, {VECS[i].duty, 6'd0});
      trig_freq(VECS[i].freq);
      measure(hi, lo);
      chk($sformatf("R2 R4 row%0d high", i), hi, int'(VECS[i].hi));
      chk($sformatf("R1 R4 row%0d low", i), lo, int'(VECS[i].lo));
      chk($sformatf("R11 row%0d active", i), int'(active), 1);
    end

    // R10 overflow at trigger: 0x700 + 0x380 > 0x7FF
    wr(2'd0, 8'h11);
    trig_freq(11'h700);
    chk("R10 trigger overflow", int'(active), 0);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (tone) cnt++; end
    chk("R11 silent while inactive", cnt, 0);

    // R11 writes while inactive take effect
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    trig_freq(11'h7FC);
    chk("R11 retrigger active", int'(active), 1);
    measure(hi, lo);
    chk("R11 freq written while inactive", hi, 4);

    // R6 R7 shadow sweep upward, shift 5: 0x780 -> 0x7BC, lookahead kills next
    freq_tick = 1'b0;
    wr(2'd0, 8'h15);
    trig_freq(11'h780);
    chk("R6 active", int'(active), 1);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    stick();
    freq_tick = 1'b1;
    measure(hi, lo);
    chk("R6 sweep from shadow high", hi, 68);
    chk("R7 sweep from shadow low", lo, 476);
    chk("R10 still active", int'(active), 1);
    stick();
    chk("R10 lookahead kill", int'(active), 0);

    // R7 decrease, shift 3: 0x7F0 -> 0x6F2, step 270
    wr(2'd0, 8'h1B);
    trig_freq(11'h7F0);
    stick();
    measure(hi, lo);
    chk("R7 decrease step", hi, 270);
    chk("R7 decrease active", int'(active), 1);

    // R8 period 2
    wr(2'd0, 8'h25);
    trig_freq(11'h780);
    stick();
    measure(hi, lo);
    chk("R8 no update after one tick", hi, 128);
    stick();
    measure(hi, lo);
    chk("R8 update after second tick", hi, 68);

    // R8 period 0 disables
    wr(2'd0, 8'h0B);
    trig_freq(11'h7F0);
    stick(); stick(); stick();
    measure(hi, lo);
    chk("R8 period0 no update", hi, 16);

    // R9 shift 0
    wr(2'd0, 8'h10);
    trig_freq(11'h7F0);
    stick(); stick(); stick();
    measure(hi, lo);
    chk("R9 shift0 no change", hi, 16);
    chk("R9 shift0 active", int'(active), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule